// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into the physical address that a real-mode processor places on its bus. It supports two address models. In the compatible model the segment moves up by four bits and the offset is added, giving a 1 Mbyte space. In the extended model the segment moves up by eight bits before the offset is added, giving a 16 Mbyte space. A mode input is sampled with every access, so software can switch models between two consecutive accesses.

Two other kinds of access skip the segment arithmetic. An I/O access always yields a 16-bit port number, even in the extended model. The first instruction fetch after reset goes to one fixed location that is the same in both models. Each access is presented for one cycle with `req_valid`. The registered result appears on the next clock edge, marked by `addr_valid`, and it holds its value while no access is presented.

A small state register records the class of the access currently held at the output. There are five states. `S_IDLE` means no result is valid. `S_MEM20` holds a compatible-model memory address, `S_MEM24` holds an extended-model memory address, `S_PORT` holds an I/O port address and `S_BOOT` holds the reset fetch address. Each cycle the next state is chosen from the inputs alone: no request gives `S_IDLE`. Otherwise `boot_fetch` gives `S_BOOT`, or else `is_io` gives `S_PORT`, or else `ext_mode` chooses between `S_MEM24` and `S_MEM20`. Any state can move to any other in one cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: A compatible-model memory access (`ext_mode`=0, `is_io`=0, `boot_fetch`=0) yields ((seg << 4) + ofs) modulo 2^20.
- R2: An extended-model memory access (`ext_mode`=1, `is_io`=0, `boot_fetch`=0) yields ((seg << 8) + ofs) modulo 2^24.
- R3: With seg 0x4000 and ofs 0x0100, the compatible result is 0x040100 and the extended result is 0x400100.
- R4: In the compatible model, address bits 23:20 are always zero. This includes bits 23:21.
- R5: A request with `boot_fetch`=1 yields 0x0FFFF0, whatever the values of `ext_mode`, `is_io`, seg and ofs.
- R6: A request with `is_io`=1 and `boot_fetch`=0 yields {8'h00, ofs}. The segment and `ext_mode` have no effect on it.
- R7: `addr_valid` is high in exactly the cycle after a cycle with `req_valid`=1. When `req_valid`=0, `addr` keeps its previous value.
- R8: While `rst_n` is low, and after it is released until the first request, `addr_valid` is 0 and `addr` is 0.
- R9: `ext_mode` applies only to the access it comes with. Back-to-back accesses that alternate the model each produce the result of their own model.
- R10: When inputs conflict, `boot_fetch` wins over `is_io`, and `is_io` wins over the memory models.
- R11: In the compatible model a carry out of bit 19 is discarded (seg 0xFFFF, ofs 0xFFFF gives 0x00FFEF). In the extended model a carry out of bit 23 is discarded (the same inputs give 0x00FEFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| seg | input | 16 | Segment value |
| ofs | input | 16 | Offset within the segment, or port number for I/O |
| ext_mode | input | 1 | 1 selects the 16 Mbyte model, 0 the 1 Mbyte model |
| is_io | input | 1 | 1 marks an I/O access |
| boot_fetch | input | 1 | 1 marks the first fetch after reset |
| addr | output | 24 | Registered physical address |
| addr_valid | output | 1 | `addr` holds the result of the previous cycle's request |

## Verification
Boot fetch, I/O mapping and the extended arithmetic can all be requested in the same cycle. The bench therefore raises `boot_fetch` together with `is_io` and `ext_mode`, using a segment that would give a different address under every other rule, and expects only the fixed reset location. It also raises `is_io` with `ext_mode` and a non-zero segment, and expects the bare port number. A mode switch can also fall on the cycle right after another access. Back-to-back requests that alternate `ext_mode` on the same segment and offset must each be judged by their own model.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_W     = 16;
    localparam int OFS_W     = 16;
    localparam int ADDR_W    = 24;
    localparam int CMP_W     = 20;
    localparam int CMP_SHIFT = 4;
    localparam int EXT_SHIFT = 8;
    localparam int PORT_W    = 16;
    localparam logic [ADDR_W-1:0] BOOT_ADDR = 24'h0FFFF0;

    // class of the access held at the output
    typedef enum logic [2:0] {
        S_IDLE,
        S_MEM20,
        S_MEM24,
        S_PORT,
        S_BOOT
    } acc_state_e;
endpackage

// File: rtl/seg_sum.sv
module seg_sum #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int SUM_W = 20,
    parameter int OUT_W = 24
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [OUT_W-1:0] sum_o
);
    logic [SUM_W-1:0] seg_x;
    logic [SUM_W-1:0] sum_x;

    // the sum is kept to SUM_W bits, so any carry above it is lost
    assign seg_x = SUM_W'(seg_i) << SHIFT;
    assign sum_x = seg_x + SUM_W'(ofs_i);
    assign sum_o = OUT_W'(sum_x);
endmodule

// File: rtl/addr_pick.sv
module addr_pick
    import seg_addr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PORT_W = 16,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 24'h0FFFF0
) (
    input  acc_state_e        cls_i,
    input  logic [ADDR_W-1:0] sum20_i,
    input  logic [ADDR_W-1:0] sum24_i,
    input  logic [PORT_W-1:0] port_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        unique case (cls_i)
            S_MEM20: addr_o = sum20_i;
            S_MEM24: addr_o = sum24_i;
            S_PORT:  addr_o = ADDR_W'(port_i);
            S_BOOT:  addr_o = BOOT_ADDR;
            default: addr_o = '0;
        endcase
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int G_SEG_W     = SEG_W,
    parameter int G_OFS_W     = OFS_W,
    parameter int G_ADDR_W    = ADDR_W,
    parameter int G_CMP_W     = CMP_W,
    parameter int G_CMP_SHIFT = CMP_SHIFT,
    parameter int G_EXT_SHIFT = EXT_SHIFT,
    parameter int G_PORT_W    = PORT_W,
    parameter logic [G_ADDR_W-1:0] G_BOOT_ADDR = BOOT_ADDR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [G_SEG_W-1:0]  seg,
    input  logic [G_OFS_W-1:0]  ofs,
    input  logic                ext_mode,
    input  logic                is_io,
    input  logic                boot_fetch,
    output logic [G_ADDR_W-1:0] addr,
    output logic                addr_valid
);
    localparam int N_MODES = 2;

    acc_state_e          state_q, state_d;
    logic [G_ADDR_W-1:0] sums [N_MODES];
    logic [G_ADDR_W-1:0] addr_d;
    logic [G_ADDR_W-1:0] addr_q;

    // index 0: compatible model, index 1: extended model
    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        localparam int SH = (m == 0) ? G_CMP_SHIFT : G_EXT_SHIFT;
        localparam int SW = (m == 0) ? G_CMP_W : G_ADDR_W;
        seg_sum #(
            .SEG_W (G_SEG_W),
            .OFS_W (G_OFS_W),
            .SHIFT (SH),
            .SUM_W (SW),
            .OUT_W (G_ADDR_W)
        ) i_sum (
            .seg_i (seg),
            .ofs_i (ofs),
            .sum_o (sums[m])
        );
    end

    // next-state choice, in priority order: boot, port, extended, compatible
    always_comb begin
        state_d = S_IDLE;
        if (req_valid) begin
            if (boot_fetch)    state_d = S_BOOT;
            else if (is_io)    state_d = S_PORT;
            else if (ext_mode) state_d = S_MEM24;
            else               state_d = S_MEM20;
        end
    end

    addr_pick #(
        .ADDR_W    (G_ADDR_W),
        .PORT_W    (G_PORT_W),
        .BOOT_ADDR (G_BOOT_ADDR)
    ) i_pick (
        .cls_i   (state_d),
        .sum20_i (sums[0]),
        .sum24_i (sums[1]),
        .port_i  (ofs[G_PORT_W-1:0]),
        .addr_o  (addr_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // output register, loaded only when an access is presented
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                addr_q <= '0;
        else if (state_d != S_IDLE) addr_q <= addr_d;
    end

    assign addr       = addr_q;
    assign addr_valid = (state_q != S_IDLE);

    // R7
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && $stable(addr)));
    // R5
    boot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && boot_fetch) |=> (addr == G_BOOT_ADDR));
    // R6
    port_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !boot_fetch && is_io) |=>
            (addr == G_ADDR_W'($past(ofs[G_PORT_W-1:0]))));
    // R4
    compat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !boot_fetch && !is_io && !ext_mode) |=>
            (addr[G_ADDR_W-1:G_CMP_W] == '0));
endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] seg = '0;
    logic [15:0] ofs = '0;
    logic        ext_mode = 1'b0;
    logic        is_io = 1'b0;
    logic        boot_fetch = 1'b0;
    logic [23:0] addr;
    logic        addr_valid;

    int vectors = 0;
    int misses  = 0;
    logic [23:0] last_addr = '0;
    bit done = 1'b0;

    typedef struct {
        logic        v;
        logic [23:0] a;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg(seg), .ofs(ofs),
        .ext_mode(ext_mode), .is_io(is_io), .boot_fetch(boot_fetch),
        .addr(addr), .addr_valid(addr_valid)
    );

    function automatic logic [23:0] model(logic [15:0] s, logic [15:0] o,
                                          logic e, logic io, logic b);
        logic [31:0] t;
        if (b)  return 24'h0FFFF0;
        if (io) return {8'h00, o};
        if (e) begin
            t = ({16'h0, s} << 8) + {16'h0, o};
            return t[23:0];
        end
        t = ({16'h0, s} << 4) + {16'h0, o};
        return {4'h0, t[19:0]};
    endfunction

    task automatic access(logic [15:0] s, logic [15:0] o, logic e, logic io,
                          logic b, logic [23:0] exp_a, string tag);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b1; seg = s; ofs = o; ext_mode = e; is_io = io; boot_fetch = b;
        it.v = 1'b1; it.a = exp_a; it.tag = tag;
        last_addr = exp_a;
        sb.push_back(it);
    endtask

    task automatic idle(string tag);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b0; seg = 16'hDEAD; ofs = 16'hBEEF;
        ext_mode = 1'b1; is_io = 1'b1; boot_fetch = 1'b1;
        it.v = 1'b0; it.a = last_addr; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                vectors++;
                if (addr_valid !== it.v || addr !== it.a) begin
                    misses++;
                    $display("FAIL %s: valid=%0b addr=%06h expected valid=%0b addr=%06h",
                             it.tag, addr_valid, addr, it.v, it.a);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (addr_valid !== 1'b0 || addr !== 24'h0) begin
            misses++;
            $display("FAIL R8: valid=%0b addr=%06h expected valid=0 addr=000000", addr_valid, addr);
        end
        @(negedge clk) rst_n = 1'b1;
        idle("R8");
        idle("R8");
        // R3 example values, literal expectations
        access(16'h4000, 16'h0100, 1'b0, 1'b0, 1'b0, 24'h040100, "R3");
        access(16'h4000, 16'h0100, 1'b1, 1'b0, 1'b0, 24'h400100, "R3");
        // R1 / R2 ordinary patterns
        access(16'h1234, 16'h5678, 1'b0, 1'b0, 1'b0, model(16'h1234, 16'h5678, 0, 0, 0), "R1");
        access(16'h1234, 16'h5678, 1'b1, 1'b0, 1'b0, model(16'h1234, 16'h5678, 1, 0, 0), "R2");
        access(16'hA5C3, 16'h3C5A, 1'b1, 1'b0, 1'b0, model(16'hA5C3, 16'h3C5A, 1, 0, 0), "R2");
        // R11 carry discard in both models
        access(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 24'h00FFEF, "R11");
        access(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 24'h00FEFF, "R11");
        // R4 compatible top of range keeps bits 23:20 zero
        access(16'hF000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 24'h0FFFFF, "R4");
        // R7 idle cycle holds the address
        idle("R7");
        // R6 ports ignore segment and model
        access(16'hABCD, 16'h03F8, 1'b1, 1'b1, 1'b0, 24'h0003F8, "R6");
        access(16'h1234, 16'hFFFF, 1'b0, 1'b1, 1'b0, 24'h00FFFF, "R6");
        // R5 / R10 boot overrides everything
        access(16'h1234, 16'h5555, 1'b1, 1'b0, 1'b1, 24'h0FFFF0, "R5");
        access(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1, 24'h0FFFF0, "R10");
        access(16'h8000, 16'h0042, 1'b0, 1'b1, 1'b1, 24'h0FFFF0, "R10");
        // R9 alternating models back to back
        access(16'h4000, 16'h0100, 1'b1, 1'b0, 1'b0, 24'h400100, "R9");
        access(16'h4000, 16'h0100, 1'b0, 1'b0, 1'b0, 24'h040100, "R9");
        access(16'h4000, 16'h0100, 1'b1, 1'b0, 1'b0, 24'h400100, "R9");
        idle("R7");
        idle("R7");
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule